// File: doc/BRIEF.md
# Bidirectional GPIO Port with Pull-up Control

This block controls a port of general-purpose pins. Each pin has a direction bit, an output-data bit, a pull-up enable bit and a sampled input bit. Software reaches these groups through a small synchronous register bus. The bus has a 2-bit select, a write enable, a write-data word and a combinational read-data word. Toward the pads, the block drives an output-enable, an output value and a pull-up request for each pin. It also takes back the level seen on each pad.

The pad level passes through a two-stage synchronizer before software can read it. The first stage is a latch that is open while the clock is low. The second stage is a flip-flop on the rising edge. A sleep input forces the sampled level to 0 ahead of the synchronizer, so a floating pad cannot disturb it. Writing ones to the input-register address flips the matching output-data bits. This lets software change single pins without a read-modify-write.

Top module: `gpio_port`

## Requirements
- R1: While rst_n is low and after reset, the direction, output-data and pull-up registers are 0, so pad_oe, pad_out and pad_pu are 0 and every register read returns 0.
- R2: A write with reg_sel=0 loads the direction register. pad_oe equals that register, where bit value 1 means the pin drives its pad.
- R3: A write with reg_sel=1 loads the output-data register, and pad_out equals it.
- R4: A write with reg_sel=3 inverts each output-data bit whose write-data bit is 1. Bits written with 0 keep their value.
- R5: A write with reg_sel=2 loads the pull-up register. pad_pu equals it, whatever the direction bits hold.
- R6: rd_data returns the direction register for reg_sel 0, output data for 1, pull-up for 2 and the synchronized pad level for 3. Reading changes no state.
- R7: A pad level applied just after one rising edge and held through the low phase appears on the reg_sel=3 read after the next rising edge, and not before that edge.
- R8: While sleep is 1, the level entering the synchronizer is 0. A sleep level held through a low phase makes the reg_sel=3 read 0 after the next rising edge, and pad sampling resumes once sleep returns to 0.
- R9: With wr_en low, wr_data and reg_sel change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | I/O clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep | input | 1 | Blocks the pad input path when 1 |
| reg_sel | input | 2 | Register select: 0 direction, 1 output data, 2 pull-up, 3 pin input |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | W | Write data |
| rd_data | output | W | Read data of the selected register |
| pad_in | input | W | Level seen on each pad |
| pad_out | output | W | Value driven when enabled |
| pad_oe | output | W | Output enable per pin |
| pad_pu | output | W | Pull-up request per pin |

## Verification
The reference model is tried with several mixes of direction and data values. Alternating patterns separate the pad_oe, pad_out and pad_pu wiring from one another. Toggle writes use masks with both ones and zeros, and are applied to a register that already holds a mix of bits. This catches a plain load and an inverted mask. Pad patterns that change every cycle test the one-edge latency, and a stage that is missing or extra shows up as a one-cycle skew. Sleep is raised while the pad level is high, so the gating is seen as a change to 0 and then a recovery.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  typedef enum logic [1:0] {
    SEL_DIR  = 2'd0,
    SEL_OUT  = 2'd1,
    SEL_PULL = 2'd2,
    SEL_IN   = 2'd3
  } gpio_sel_e;

  // Output-data update for a toggle write: ones in the mask flip bits
  function automatic logic [63:0] flip_bits(input logic [63:0] cur,
                                            input logic [63:0] mask);
    return cur ^ mask;
  endfunction

  // Input seen by the synchronizer, held low during sleep
  function automatic logic [63:0] gate_pad(input logic        slp,
                                           input logic [63:0] pad);
    return slp ? '0 : pad;
  endfunction

endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   reg_sel,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] out_q,
  output logic [W-1:0] pull_q,
  output logic         wr_dir_evt,
  output logic         wr_out_evt,
  output logic         wr_pull_evt,
  output logic         wr_tog_evt
);
  import gpio_pkg::*;

  localparam int PADW = 64 - W;

  gpio_sel_e    sel;
  logic [63:0]  flip_full;
  logic [W-1:0] out_flip;

  assign sel         = gpio_sel_e'(reg_sel);
  assign wr_dir_evt  = wr_en && (sel == SEL_DIR);
  assign wr_out_evt  = wr_en && (sel == SEL_OUT);
  assign wr_pull_evt = wr_en && (sel == SEL_PULL);
  assign wr_tog_evt  = wr_en && (sel == SEL_IN);

  assign flip_full = flip_bits({{PADW{1'b0}}, out_q}, {{PADW{1'b0}}, wr_data});
  assign out_flip  = flip_full[W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      out_q  <= '0;
      pull_q <= '0;
    end else begin
      if (wr_dir_evt)  dir_q  <= wr_data;
      if (wr_pull_evt) pull_q <= wr_data;
      if (wr_out_evt)      out_q <= wr_data;
      else if (wr_tog_evt) out_q <= out_flip;
    end
  end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sleep,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] gated,
  output logic [W-1:0] sense_q
);
  import gpio_pkg::*;

  localparam int PADW = 64 - W;

  logic [63:0]  gated_full;
  logic [W-1:0] lat_q;

  assign gated_full = gate_pad(sleep, {{PADW{1'b0}}, pad_in});
  assign gated      = gated_full[W-1:0];

  for (genvar b = 0; b < W; b++) begin : g_bit
    // first stage: open during the low clock phase
    always_latch begin
      if (!clk) lat_q[b] <= gated[b];
    end
    // second stage: rising edge
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sense_q[b] <= 1'b0;
      else        sense_q[b] <= lat_q[b];
    end
  end

endmodule

// File: rtl/gpio_rd_mux.sv
module gpio_rd_mux #(
  parameter int W = 8
) (
  input  logic [1:0]   reg_sel,
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] out_q,
  input  logic [W-1:0] pull_q,
  input  logic [W-1:0] sense_q,
  output logic [W-1:0] rd_data
);
  import gpio_pkg::*;

  always_comb begin
    unique case (gpio_sel_e'(reg_sel))
      SEL_DIR:  rd_data = dir_q;
      SEL_OUT:  rd_data = out_q;
      SEL_PULL: rd_data = pull_q;
      SEL_IN:   rd_data = sense_q;
      default:  rd_data = '0;
    endcase
  end

endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sleep,
  input  logic [1:0]   reg_sel,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_pu
);

  logic [W-1:0] dir_q, out_q, pull_q, sense_q, gated;
  logic         wr_dir_evt, wr_out_evt, wr_pull_evt, wr_tog_evt;

  gpio_cfg_regs #(.W(W)) regs_i (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
    .wr_data(wr_data), .dir_q(dir_q), .out_q(out_q), .pull_q(pull_q),
    .wr_dir_evt(wr_dir_evt), .wr_out_evt(wr_out_evt),
    .wr_pull_evt(wr_pull_evt), .wr_tog_evt(wr_tog_evt)
  );

  gpio_in_sync #(.W(W)) sync_i (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .pad_in(pad_in),
    .gated(gated), .sense_q(sense_q)
  );

  gpio_rd_mux #(.W(W)) mux_i (
    .reg_sel(reg_sel), .dir_q(dir_q), .out_q(out_q), .pull_q(pull_q),
    .sense_q(sense_q), .rd_data(rd_data)
  );

  assign pad_oe  = dir_q;
  assign pad_out = out_q;
  assign pad_pu  = pull_q;

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         sleep,
  input logic [1:0]   reg_sel,
  input logic         wr_en,
  input logic [W-1:0] wr_data,
  input logic [W-1:0] rd_data,
  input logic [W-1:0] pad_out,
  input logic [W-1:0] pad_oe,
  input logic [W-1:0] pad_pu,
  input logic [W-1:0] gated,
  input logic         wr_tog_evt,
  input logic         wr_pull_evt
);

  a_r4_toggle_flips: assert property (@(posedge clk) disable iff (!rst_n)
    wr_tog_evt |=> pad_out == ($past(pad_out) ^ $past(wr_data)));

  a_r2_dir_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel == 2'd0) |=> pad_oe == $past(wr_data));

  a_r5_pull_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_pull_evt |=> $stable(pad_pu));

  a_r6_read_dir: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel == 2'd0) |-> rd_data == pad_oe);

  a_r8_sleep_gates: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> gated == '0);

  a_r8_sleep_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sleep) && reg_sel == 2'd3) |-> rd_data == '0);

endmodule

bind gpio_port gpio_port_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .sleep(sleep), .reg_sel(reg_sel),
  .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
  .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu),
  .gated(gated), .wr_tog_evt(wr_tog_evt), .wr_pull_evt(wr_pull_evt)
);

// File: tb/gpio_port_tb.sv
module gpio_port_tb_top;
  localparam int W = 8;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sleep = 1'b0;
  logic [1:0]   reg_sel = 2'd0;
  logic         wr_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] pad_in = '0;
  logic [W-1:0] rd_data, pad_out, pad_oe, pad_pu;

  int errors = 0;
  int checks = 0;
  bit started = 0;
  bit done = 0;
  string phase = "R1";

  // behavioural reference state
  int m_dir = 0, m_out = 0, m_pu = 0, m_pin = 0;

  gpio_port #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .reg_sel(reg_sel),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dir = 0; m_out = 0; m_pu = 0; m_pin = 0;
    end else begin
      m_pin = sleep ? 0 : int'(pad_in);
      if (wr_en) begin
        if (reg_sel == 2'd0) m_dir = int'(wr_data);
        if (reg_sel == 2'd1) m_out = int'(wr_data);
        if (reg_sel == 2'd2) m_pu  = int'(wr_data);
        if (reg_sel == 2'd3) begin
          for (int b = 0; b < W; b++)
            if (wr_data[b]) m_out = m_out ^ (1 << b);
        end
      end
    end
  end

  task automatic check(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", phase, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      int exp_rd;
      case (reg_sel)
        2'd0: exp_rd = m_dir;
        2'd1: exp_rd = m_out;
        2'd2: exp_rd = m_pu;
        default: exp_rd = m_pin;
      endcase
      check("pad_oe", int'(pad_oe), m_dir);
      check("pad_out", int'(pad_out), m_out);
      check("pad_pu", int'(pad_pu), m_pu);
      check("rd_data", int'(rd_data), exp_rd);
    end
  end

  task automatic step(input logic [1:0] s, input logic w, input logic [W-1:0] d);
    reg_sel = s; wr_en = w; wr_data = d;
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    started = 1;
    phase = "R1";
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    for (int s = 0; s < 4; s++) step(2'(s), 1'b0, '0);
    phase = "R2";
    step(2'd0, 1'b1, 8'hA5);
    step(2'd0, 1'b0, '0);
    phase = "R3";
    step(2'd1, 1'b1, 8'h3C);
    step(2'd1, 1'b0, '0);
    phase = "R4";
    step(2'd3, 1'b1, 8'h0F);
    step(2'd3, 1'b1, 8'h81);
    step(2'd3, 1'b1, 8'h00);
    step(2'd1, 1'b0, '0);
    phase = "R5";
    step(2'd2, 1'b1, 8'h5A);
    step(2'd0, 1'b1, 8'hFF);
    step(2'd2, 1'b0, '0);
    phase = "R9";
    step(2'd1, 1'b0, 8'hFF);
    step(2'd2, 1'b0, 8'h00);
    step(2'd0, 1'b0, 8'h00);
    phase = "R6";
    for (int s = 0; s < 4; s++) step(2'(s), 1'b0, 8'h77);
    phase = "R7";
    reg_sel = 2'd3;
    for (int k = 0; k < 10; k++) begin
      pad_in = 8'(k * 37 + 11);
      step(2'd3, 1'b0, '0);
    end
    phase = "R8";
    pad_in = 8'hFF;
    step(2'd3, 1'b0, '0);
    sleep = 1'b1;
    step(2'd3, 1'b0, '0);
    step(2'd3, 1'b0, '0);
    pad_in = 8'hC3;
    step(2'd3, 1'b0, '0);
    sleep = 1'b0;
    step(2'd3, 1'b0, '0);
    step(2'd3, 1'b0, '0);
    phase = "R1";
    #2 rst_n = 1'b0;
    @(negedge clk);
    step(2'd0, 1'b0, '0);
    #1 rst_n = 1'b1;
    step(2'd1, 1'b0, '0);
    step(2'd2, 1'b0, '0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule